// File: doc/BRIEF.md
# Bridge Converter Serial Reader

This block sits on the host side of an 18-bit delta-sigma bridge-sensor converter. The converter has one pin that does two jobs. It pulls the pin low to say that a result is waiting, and it then puts the result bits on the same pin. The reader watches that pin while it is idle. When the pin goes low, the reader drives a serial clock to fetch the 18 data bits, most significant bit first. It then gives one more clock pulse, which sends the pin high again so that the next ready indication can be polled.

The fetched code is in two's complement. The reader sign-extends it to a 24-bit bus and publishes it with a single-cycle valid strobe. A flag on the same bus marks a code at either end of the range. After the host switches the input multiplexer, the converter's first few readings have not settled. A channel-change pulse therefore arms a counter, and the matching number of completed reads is dropped without a strobe. The reader also drives the converter's rate-select pin. If the pin does not fall within a wait limit tied to the chosen rate, it raises a timeout pulse and keeps waiting.

Top module: `bridge_adc_reader`

## Requirements
- R1: While reset is held and after it is released, the serial clock, valid strobe, saturation flag, timeout pulse and rate-select output are all 0, and the result bus is 0. The discard counter also starts at zero, so the first completed read is published.
- R2: The shared line passes through a two-flop synchroniser. While idle, the serial clock stays low until the synchronised line reads 0, and that low level starts a read.
- R3: Each read issues exactly 19 serial-clock pulses. Every high phase lasts HALF_CLKS clock cycles, and so does every low phase between pulses. One data bit is taken from the synchronised line at the end of each of the first 18 high phases, most significant bit first.
- R4: The 18-bit code is published on `result_o` sign-extended to 24 bits (bit 17 copied into bits 23..18). `result_valid_o` is high for exactly one cycle, 2*HALF_CLKS cycles after the rising edge of the 19th pulse.
- R5: `result_sat_o` is 1 together with a published result when the code is 0x1FFFF (positive full scale) or 0x20000 (negative full scale), and 0 for any other code.
- R6: A `chan_switch_i` pulse loads the discard counter with SETTLE_READS (4). Each completed read while the counter is non-zero gives no valid strobe and lowers the counter by one, and reads then resume being published.
- R7: A channel-change pulse in the same cycle as a read's completion wins. That read is dropped and the counter is reloaded to the full count, not lowered.
- R8: `adc_speed_o` follows `rate_fast_i` with one cycle of delay: 0 selects the slow (nominal 10 samples/s) rate and 1 selects the fast (nominal 80 samples/s) rate.
- R9: While idle with the line high, `timeout_err_o` pulses for one cycle every WAIT_SLOW cycles (when `adc_speed_o` is 0) or every WAIT_FAST cycles (when it is 1). The wait then restarts.
- R10: Neither the valid strobe nor the timeout pulse is ever high while the serial clock is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| rate_fast_i | input | 1 | Rate request: 1 fast, 0 slow |
| chan_switch_i | input | 1 | One-cycle pulse: input multiplexer has switched |
| adc_line_i | input | 1 | Shared ready/data line from the converter |
| adc_sclk_o | output | 1 | Serial clock to the converter |
| adc_speed_o | output | 1 | Rate-select pin of the converter |
| result_o | output | 24 | Sign-extended conversion result |
| result_valid_o | output | 1 | One-cycle strobe for a settled result |
| result_sat_o | output | 1 | Result is a full-scale code |
| timeout_err_o | output | 1 | One-cycle pulse: no ready within the wait limit |

## Verification
The bench builds the reader with HALF_CLKS at 3, which is the shortest phase that lets a data bit clear the synchroniser before it is sampled, so any off-by-one in the sampling point corrupts the results. WAIT_SLOW is set to 300 and WAIT_FAST to 120, so both timeout periods can be measured exactly within a short run, and a switch between the two rates can be watched as well. SETTLE_READS stays at 4. A whole discard window can therefore be run through, as can a channel change placed on the exact completion cycle of a read.

// File: rtl/badc_pkg.sv
package badc_pkg;

    // Converter word format and host bus width.
    localparam int unsigned CODE_W = 18;
    localparam int unsigned BUS_W  = 24;

    typedef enum logic [1:0] {
        ST_WAIT = 2'd0,
        ST_HIGH = 2'd1,
        ST_LOW  = 2'd2
    } rd_state_e;

    typedef struct packed {
        logic [BUS_W-1:0] value;
        logic             sat;
    } sample_t;

    function automatic logic [BUS_W-1:0] sign_extend(input logic [CODE_W-1:0] code);
        return {{(BUS_W - CODE_W){code[CODE_W-1]}}, code};
    endfunction

    function automatic logic at_full_scale(input logic [CODE_W-1:0] code);
        logic [CODE_W-1:0] top_code;
        logic [CODE_W-1:0] bot_code;
        top_code = {1'b0, {(CODE_W - 1){1'b1}}};
        bot_code = {1'b1, {(CODE_W - 1){1'b0}}};
        return (code == top_code) || (code == bot_code);
    endfunction

    function automatic sample_t pack_sample(input logic [CODE_W-1:0] code);
        sample_t s;
        s.value = sign_extend(code);
        s.sat   = at_full_scale(code);
        return s;
    endfunction

endpackage

// File: rtl/badc_sync.sv
module badc_sync #(
    parameter int unsigned STAGES  = 2,
    parameter logic        RST_VAL = 1'b1
) (
    input  logic clk,
    input  logic rst,
    input  logic d_i,
    output logic q_o
);
    logic [STAGES-1:0] chain_q;

    genvar g;
    generate
        for (g = 0; g < STAGES; g++) begin : g_stage
            if (g == 0) begin : g_first
                always_ff @(posedge clk) begin
                    if (rst) chain_q[g] <= RST_VAL;
                    else     chain_q[g] <= d_i;
                end
            end else begin : g_next
                always_ff @(posedge clk) begin
                    if (rst) chain_q[g] <= RST_VAL;
                    else     chain_q[g] <= chain_q[g-1];
                end
            end
        end
    endgenerate

    assign q_o = chain_q[STAGES-1];
endmodule

// File: rtl/badc_settle.sv
module badc_settle #(
    parameter int unsigned COUNT = 4
) (
    input  logic clk,
    input  logic rst,
    input  logic reload_i,
    input  logic done_i,
    output logic pass_o
);
    localparam int unsigned CNT_W = $clog2(COUNT + 1);
    localparam logic [CNT_W-1:0] FULL = CNT_W'(COUNT);

    logic [CNT_W-1:0] left_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            left_q <= '0;
        end else if (reload_i) begin
            left_q <= FULL;
        end else if (done_i && (left_q != '0)) begin
            left_q <= left_q - 1'b1;
        end
    end

    assign pass_o = done_i && !reload_i && (left_q == '0);
endmodule

// File: rtl/badc_timeout.sv
module badc_timeout #(
    parameter int unsigned LIM_SLOW = 300,
    parameter int unsigned LIM_FAST = 120
) (
    input  logic clk,
    input  logic rst,
    input  logic run_i,
    input  logic fast_i,
    output logic expire_o
);
    localparam int unsigned LIM_MAX = (LIM_SLOW > LIM_FAST) ? LIM_SLOW : LIM_FAST;
    localparam int unsigned CNT_W   = $clog2(LIM_MAX + 1);
    localparam logic [CNT_W-1:0] LAST_SLOW = CNT_W'(LIM_SLOW - 1);
    localparam logic [CNT_W-1:0] LAST_FAST = CNT_W'(LIM_FAST - 1);

    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W-1:0] last;

    assign last     = fast_i ? LAST_FAST : LAST_SLOW;
    assign expire_o = run_i && (cnt_q >= last);

    always_ff @(posedge clk) begin
        if (rst || !run_i) begin
            cnt_q <= '0;
        end else if (expire_o) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_q + 1'b1;
        end
    end
endmodule

// File: rtl/bridge_adc_reader.sv
module bridge_adc_reader
    import badc_pkg::*;
#(
    parameter int unsigned HALF_CLKS    = 4,
    parameter int unsigned SYNC_STAGES  = 2,
    parameter int unsigned SETTLE_READS = 4,
    parameter int unsigned WAIT_SLOW    = 12_000_000,
    parameter int unsigned WAIT_FAST    = 1_500_000
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             rate_fast_i,
    input  logic             chan_switch_i,
    input  logic             adc_line_i,
    output logic             adc_sclk_o,
    output logic             adc_speed_o,
    output logic [BUS_W-1:0] result_o,
    output logic             result_valid_o,
    output logic             result_sat_o,
    output logic             timeout_err_o
);
    localparam int unsigned PH_W  = (HALF_CLKS > 1) ? $clog2(HALF_CLKS) : 1;
    localparam int unsigned BIT_W = $clog2(CODE_W + 1);
    localparam logic [PH_W-1:0]  PH_LAST  = PH_W'(HALF_CLKS - 1);
    localparam logic [BIT_W-1:0] BIT_LAST = BIT_W'(CODE_W);

    rd_state_e         state_q;
    logic [PH_W-1:0]   ph_q;
    logic [BIT_W-1:0]  bit_q;
    logic [CODE_W-1:0] shift_q;
    sample_t           out_q;
    logic              valid_q;
    logic              err_q;
    logic              sclk_q;
    logic              speed_q;

    logic line_s;
    logic phase_end;
    logic read_done;
    logic keep_read;
    logic expire;
    logic wait_run;

    badc_sync #(
        .STAGES (SYNC_STAGES),
        .RST_VAL(1'b1)
    ) u_sync (
        .clk(clk),
        .rst(rst),
        .d_i(adc_line_i),
        .q_o(line_s)
    );

    badc_settle #(
        .COUNT(SETTLE_READS)
    ) u_settle (
        .clk     (clk),
        .rst     (rst),
        .reload_i(chan_switch_i),
        .done_i  (read_done),
        .pass_o  (keep_read)
    );

    assign wait_run = (state_q == ST_WAIT) && line_s;

    badc_timeout #(
        .LIM_SLOW(WAIT_SLOW),
        .LIM_FAST(WAIT_FAST)
    ) u_timeout (
        .clk     (clk),
        .rst     (rst),
        .run_i   (wait_run),
        .fast_i  (speed_q),
        .expire_o(expire)
    );

    assign phase_end = (state_q != ST_WAIT) && (ph_q == PH_LAST);
    assign read_done = (state_q == ST_LOW) && phase_end && (bit_q == BIT_LAST);

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_WAIT;
            ph_q    <= '0;
            bit_q   <= '0;
            shift_q <= '0;
            out_q   <= '0;
            valid_q <= 1'b0;
            err_q   <= 1'b0;
            sclk_q  <= 1'b0;
            speed_q <= 1'b0;
        end else begin
            speed_q <= rate_fast_i;
            valid_q <= 1'b0;
            err_q   <= expire;
            unique case (state_q)
                ST_WAIT: begin
                    if (!line_s) begin
                        state_q <= ST_HIGH;
                        sclk_q  <= 1'b1;
                        ph_q    <= '0;
                        bit_q   <= '0;
                    end
                end
                ST_HIGH: begin
                    if (phase_end) begin
                        ph_q    <= '0;
                        state_q <= ST_LOW;
                        sclk_q  <= 1'b0;
                        if (bit_q < BIT_LAST) begin
                            shift_q <= {shift_q[CODE_W-2:0], line_s};
                        end
                    end else begin
                        ph_q <= ph_q + 1'b1;
                    end
                end
                ST_LOW: begin
                    if (phase_end) begin
                        ph_q <= '0;
                        if (bit_q == BIT_LAST) begin
                            state_q <= ST_WAIT;
                            if (keep_read) begin
                                valid_q <= 1'b1;
                                out_q   <= pack_sample(shift_q);
                            end
                        end else begin
                            bit_q   <= bit_q + 1'b1;
                            state_q <= ST_HIGH;
                            sclk_q  <= 1'b1;
                        end
                    end else begin
                        ph_q <= ph_q + 1'b1;
                    end
                end
                default: state_q <= ST_WAIT;
            endcase
        end
    end

    assign adc_sclk_o     = sclk_q;
    assign adc_speed_o    = speed_q;
    assign result_o       = out_q.value;
    assign result_sat_o   = out_q.sat;
    assign result_valid_o = valid_q;
    assign timeout_err_o  = err_q;
endmodule

// File: rtl/badc_checker.sv
module badc_checker
    import badc_pkg::*;
#(
    parameter int unsigned HALF_CLKS = 4
) (
    input logic             clk,
    input logic             rst,
    input logic             rate_fast_i,
    input logic             chan_switch_i,
    input logic             adc_sclk_o,
    input logic             adc_speed_o,
    input logic [BUS_W-1:0] result_o,
    input logic             result_valid_o,
    input logic             result_sat_o,
    input logic             timeout_err_o
);
    int unsigned hi_run;

    always_ff @(posedge clk) begin
        if (rst || !adc_sclk_o) hi_run <= 0;
        else                    hi_run <= hi_run + 1;
    end

    AST_HIGH_PHASE_LEN: assert property (@(posedge clk) disable iff (rst)
        $fell(adc_sclk_o) |-> (hi_run == HALF_CLKS)); // R3

    AST_SIGN_COPIES: assert property (@(posedge clk) disable iff (rst)
        result_valid_o |-> (($countones(result_o[BUS_W-1:CODE_W-1]) == 0) ||
                            ($countones(result_o[BUS_W-1:CODE_W-1]) == (BUS_W - CODE_W + 1)))); // R4

    AST_VALID_SINGLE: assert property (@(posedge clk) disable iff (rst)
        result_valid_o |=> !result_valid_o); // R4

    AST_SAT_EXTREME: assert property (@(posedge clk) disable iff (rst)
        (result_valid_o && result_sat_o) |-> (result_o[CODE_W-1] != result_o[CODE_W-2])); // R5

    AST_SWITCH_BLOCKS: assert property (@(posedge clk) disable iff (rst)
        chan_switch_i |=> !result_valid_o); // R7

    AST_SPEED_FOLLOWS: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> (adc_speed_o == $past(rate_fast_i))); // R8

    AST_ERR_IDLE_ONLY: assert property (@(posedge clk) disable iff (rst)
        timeout_err_o |-> !adc_sclk_o); // R10

    AST_VALID_IDLE_ONLY: assert property (@(posedge clk) disable iff (rst)
        result_valid_o |-> !adc_sclk_o); // R10
endmodule

bind bridge_adc_reader badc_checker #(
    .HALF_CLKS(HALF_CLKS)
) u_badc_checker (
    .clk           (clk),
    .rst           (rst),
    .rate_fast_i   (rate_fast_i),
    .chan_switch_i (chan_switch_i),
    .adc_sclk_o    (adc_sclk_o),
    .adc_speed_o   (adc_speed_o),
    .result_o      (result_o),
    .result_valid_o(result_valid_o),
    .result_sat_o  (result_sat_o),
    .timeout_err_o (timeout_err_o)
);

// File: tb/test_bridge_adc_reader.sv
`timescale 1ns/1ps
module test_bridge_adc_reader;
    localparam int H   = 3;
    localparam int SET = 4;
    localparam int LS  = 300;
    localparam int LF  = 120;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        rate_fast = 1'b1;
    logic        chan_sw = 1'b0;
    logic        line = 1'b1;
    logic        sclk, speed, valid, sat, err;
    logic [23:0] result;

    always #2.5 clk = ~clk;

    bridge_adc_reader #(
        .HALF_CLKS   (H),
        .SYNC_STAGES (2),
        .SETTLE_READS(SET),
        .WAIT_SLOW   (LS),
        .WAIT_FAST   (LF)
    ) i_bridge_adc_reader (
        .clk           (clk),
        .rst           (rst),
        .rate_fast_i   (rate_fast),
        .chan_switch_i (chan_sw),
        .adc_line_i    (line),
        .adc_sclk_o    (sclk),
        .adc_speed_o   (speed),
        .result_o      (result),
        .result_valid_o(valid),
        .result_sat_o  (sat),
        .timeout_err_o (err)
    );

    int n_checks = 0;
    int n_fail   = 0;

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    function automatic logic [23:0] widen(input logic [17:0] c);
        logic [23:0] w;
        w = {6'b0, c};
        if (c[17]) w[23:18] = 6'h3f;
        return w;
    endfunction

    // Behavioural converter: drives the shared line on serial-clock rises.
    logic [17:0] adc_code = '0;
    int          adc_bit = 19;
    bit          done_flag = 0;

    always @(posedge sclk) begin
        #1;
        if (adc_bit < 18) line = adc_code[17 - adc_bit];
        else              line = 1'b1;
        adc_bit++;
        if (adc_bit == 19) done_flag = 1;
    end

    // Reference model, compared on every falling clock edge.
    int          cyc = 0;
    int          cd = 0;
    logic [17:0] pend = '0;
    int          left = 0;
    logic        chan_prev = 1'b0;
    logic        rate_prev = 1'b0;
    bit          prev_ok = 0;
    logic        sclk_prev = 1'b0;
    int          run_len = 0;
    int          n_valid = 0;
    bit          producing = 1;
    bit          req_now = 0;
    bit          req_coin = 0;
    int          errq[$];

    always @(negedge clk) begin
        cyc++;
        if (rst) begin
            cd = 0; left = 0; prev_ok = 0; sclk_prev = 1'b0; run_len = 0;
            chan_sw = 1'b0; chan_prev = 1'b0;
        end else begin
            bit   evt;
            logic exp_v;
            evt = 0;
            if (cd > 0) begin
                cd--;
                if (cd == 0) evt = 1;
            end
            if (done_flag) begin
                done_flag = 0;
                cd = 2 * H;
                pend = adc_code;
            end
            exp_v = 1'b0;
            if (chan_prev) left = SET;
            else if (evt) begin
                exp_v = (left == 0);
                if (left > 0) left--;
            end
            chk(valid == exp_v, "R6", "valid strobe vs settle model", valid, exp_v);
            if (valid) n_valid++;
            if (valid && exp_v) begin
                chk(result == widen(pend), "R4", "sign-extended result", result, widen(pend));
                chk(sat == ((pend == 18'h1ffff) || (pend == 18'h20000)), "R5",
                    "saturation flag", sat, ((pend == 18'h1ffff) || (pend == 18'h20000)));
            end
            if (prev_ok) chk(speed == rate_prev, "R8", "rate select output", speed, rate_prev);
            if (producing) chk(!err, "R9", "no timeout while converting", err, 0);
            if (err) errq.push_back(cyc);
            if (sclk == sclk_prev) run_len++;
            else begin
                if (sclk_prev) chk(run_len == H, "R3", "sclk high phase", run_len, H);
                else if (adc_bit >= 2 && adc_bit <= 19)
                    chk(run_len == H, "R3", "sclk low phase", run_len, H);
                run_len = 1;
            end
            sclk_prev = sclk;
            rate_prev = rate_fast;
            prev_ok = 1;
            chan_sw = 1'b0;
            if (req_now) begin chan_sw = 1'b1; req_now = 0; end
            if (req_coin && cd == 1) begin chan_sw = 1'b1; req_coin = 0; end
            chan_prev = chan_sw;
        end
    end

    task automatic finish_run();
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    endtask

    task automatic wait_idle();
        wait (adc_bit >= 19 && cd == 0 && !done_flag);
    endtask

    task automatic produce(input logic [17:0] code);
        wait_idle();
        chk(adc_bit == 19, "R3", "serial pulses per read", adc_bit, 19);
        repeat (3) @(posedge clk);
        #2;
        adc_code = code;
        adc_bit  = 0;
        line     = 1'b0;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_checks++;
        n_fail++;
        $display("FAIL R2 watchdog: actual hang expected finished run");
        finish_run();
    end

    initial begin
        repeat (5) @(posedge clk);
        @(negedge clk);
        // R1: reset state
        chk(sclk == 1'b0, "R1", "sclk in reset", sclk, 0);
        chk(valid == 1'b0 && err == 1'b0, "R1", "strobes in reset", {valid, err}, 0);
        chk(result == '0 && sat == 1'b0, "R1", "result in reset", result, 0);
        chk(speed == 1'b0, "R1", "speed in reset", speed, 0);
        @(posedge clk); #2; rst = 1'b0;
        repeat (10) @(posedge clk);
        // R2: no activity while line high
        @(negedge clk);
        chk(sclk == 1'b0, "R2", "sclk idle with line high", sclk, 0);

        // fast rate, first read published at once (R1)
        produce(18'h15a5a);
        produce(18'h1ffff);
        produce(18'h20000);
        wait_idle();
        @(posedge clk); #2; rate_fast = 1'b0;
        produce(18'h00001);
        produce(18'h3ffff);
        produce(18'h00000);
        wait_idle();

        // R6: channel change discards the next four reads
        @(posedge clk); #2; req_now = 1;
        produce(18'h1fffe);
        produce(18'h20001);
        produce(18'h0abcd);
        produce(18'h3fffe);
        produce(18'h1ffff);
        produce(18'h2a5a5);
        wait_idle();

        // R7: channel change on the completion cycle
        @(posedge clk); #2; req_coin = 1;
        produce(18'h12345);
        produce(18'h00f0f);
        produce(18'h0f0f0);
        produce(18'h11111);
        produce(18'h22222);
        produce(18'h3c3c3);
        wait_idle();
        repeat (4) @(posedge clk);
        chk(n_valid == 9, "R6", "published read count", n_valid, 9);

        // R9: timeout periods at both rates
        @(posedge clk); #2; producing = 0; rate_fast = 1'b0;
        wait (errq.size() >= 4);
        chk(errq[3] - errq[2] == LS, "R9", "slow timeout period", errq[3] - errq[2], LS);
        chk(errq[2] - errq[1] == LS, "R9", "slow timeout period", errq[2] - errq[1], LS);
        @(posedge clk); #2; rate_fast = 1'b1; errq.delete();
        wait (errq.size() >= 4);
        chk(errq[3] - errq[2] == LF, "R9", "fast timeout period", errq[3] - errq[2], LF);
        chk(errq[2] - errq[1] == LF, "R9", "fast timeout period", errq[2] - errq[1], LF);
        @(negedge clk);
        chk(sclk == 1'b0, "R10", "sclk idle after timeouts", sclk, 0);
        finish_run();
    end
endmodule